// File: doc/BRIEF.md
# Dual-Timestamp Hit Event Builder

This block sits directly behind an asynchronous time-to-digital converter. The converter raises a data-ready level each time it has latched a time stamp, and it raises an energy flag when the stamp that marks the end of a pulse (the return below threshold) is available. The builder brings both strobes into the system clock domain and turns each rising edge into a single-cycle pulse. It samples the stamp once the value is stable, keeps the two most recent stamps in a two-deep row, and drives an active-low clear back to the converter so that the converter can take its next measurement.

An event pairs the older stored stamp (arrival) with the newer one (threshold crossing back down). In pair mode (`all_mode` low), an event forms only when the energy flag rose together with the data-ready strobe of the second stamp. In every-stamp mode (`all_mode` high), each captured stamp produces an event built from the two newest stamps. Events leave through a valid/ready pair. While an event waits to be taken, a new event request is discarded and a sticky flag records the loss.

Top module: `hit_event_builder`

## Requirements
- R1: Each rising edge of `tdc_ready_a` is acted on exactly once, however long the level stays high: the clear output pulses once and at most one event forms per rising edge.
- R2: Counting the first rising clock edge that sees `tdc_ready_a` high as edge 0, the stamp present at edge 3 is captured as the newest stamp, and the previous newest becomes the older stamp. An event carries the older stamp on `evt_arrival` and the newest on `evt_fall`.
- R3: `tdc_clr_n` is low for exactly two clock cycles, after edges 3 and 4, and is high after edge 5 and otherwise.
- R4: With `all_mode` = 0, an event forms only when `tdc_energy_a` rose together with `tdc_ready_a`. A stamp without the energy flag forms no event.
- R5: With `all_mode` = 1, every captured stamp forms an event, whatever the energy flag does.
- R6: A formed event is loaded at edge 4, so `evt_valid` is high from edge 4 on.
- R7: `evt_valid` stays high and `evt_arrival`/`evt_fall` stay constant until a clock edge where `evt_ready` is high. After that edge `evt_valid` falls unless a new event loads at that same edge.
- R8: An event request at an edge where `evt_valid` is high and `evt_ready` is low is dropped. The held event is unchanged, and `evt_lost` goes high and stays high until reset.
- R9: Changes on `tdc_stamp` after edge 3 of a hit have no effect on the captured stamp.
- R10: After reset, `evt_valid` = 0, `evt_lost` = 0 and `tdc_clr_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdc_ready_a | input | 1 | Asynchronous stamp-ready level from the converter |
| tdc_energy_a | input | 1 | Asynchronous end-of-pulse flag from the converter |
| tdc_stamp | input | STAMP_W | Converter time stamp |
| all_mode | input | 1 | 1: event on every stamp; 0: event on energy flag only |
| tdc_clr_n | output | 1 | Active-low clear of the converter latches |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Downstream takes the event |
| evt_arrival | output | STAMP_W | Older stamp of the event |
| evt_fall | output | STAMP_W | Newer stamp of the event |
| evt_lost | output | 1 | Sticky: an event request was dropped |

## Verification
The bench holds the ready level high for many cycles. A design that re-triggered on a level instead of an edge would pulse the clear again and emit duplicate events. The bench also changes the stamp right after the sampling edge, so a design that sampled too late would capture the wrong value. Back-pressure cases request a new event while one is still unread. A design that overwrote the held data, or failed to set and keep the loss flag, shows up as wrong output data or a missing flag. The bench also mixes the two modes and the energy flag at random, so a design that confused the modes would emit events that are not expected, or miss events that are.

// File: rtl/heb_pkg.sv
// Shared definitions for the hit event builder.
// Assumes: nothing beyond IEEE 1800-2017.
package heb_pkg;
    localparam int unsigned STAMP_W_DEF  = 16;
    localparam int unsigned SYNC_DEF     = 2;
    localparam int unsigned CLR_CYC_DEF  = 2;

    typedef enum logic {
        MODE_PAIR  = 1'b0,
        MODE_EVERY = 1'b1
    } build_mode_e;

    // Select the event request source for the active build mode.
    function automatic logic pick_req(build_mode_e mode, logic every_req, logic pair_req);
        return (mode == MODE_EVERY) ? every_req : pair_req;
    endfunction
endpackage

// File: rtl/heb_edge_sync.sv
// Brings an asynchronous level into the clock domain through a flop chain
// and emits a registered one-cycle pulse for each rising edge of it.
// Assumes: STAGES >= 2; the input stays high or low for at least two cycles.
module heb_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_p
);
    logic [STAGES-1:0] chain_q;
    logic              seen_q;
    logic              rise_c;

    // Synchronizer chain plus the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            seen_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_c = chain_q[STAGES-1] & ~seen_q;

    // Register the edge so the pulse leaves from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_p <= 1'b0;
        else        rise_p <= rise_c;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> !rise_p); // R1
endmodule

// File: rtl/heb_stamp_row.sv
// Two-deep stamp row: the hit pulse shifts the current stamp in, and a
// down-counter holds the converter clear low for CLR_CYC cycles afterwards.
// Assumes: hit pulses are at least CLR_CYC+1 cycles apart.
module heb_stamp_row #(
    parameter int unsigned STAMP_W = 16,
    parameter int unsigned CLR_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_p,
    input  logic [STAMP_W-1:0] stamp,
    output logic [STAMP_W-1:0] newest,
    output logic [STAMP_W-1:0] older,
    output logic               clr_n
);
    localparam int unsigned CNT_W = $clog2(CLR_CYC + 1);

    logic [CNT_W-1:0] clr_cnt_q;

    // Shift the newly sampled stamp into the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest <= '0;
            older  <= '0;
        end else if (hit_p) begin
            newest <= stamp;
            older  <= newest;
        end
    end

    // Count the clear window that starts right after the sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                clr_cnt_q <= '0;
        else if (hit_p)            clr_cnt_q <= CNT_W'(CLR_CYC);
        else if (clr_cnt_q != '0)  clr_cnt_q <= clr_cnt_q - 1'b1;
    end

    assign clr_n = (clr_cnt_q == '0);

    AST_CLR_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_p |=> !clr_n); // R3
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        hit_p |=> (older == $past(newest))); // R2
endmodule

// File: rtl/heb_event_out.sv
// Output event register with a valid/ready handshake. A request loads the
// stamp pair when the slot is free or being taken; otherwise it is dropped
// and a sticky loss flag is raised.
// Assumes: req is a single-cycle pulse.
module heb_event_out #(
    parameter int unsigned STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [STAMP_W-1:0] pair_old,
    input  logic [STAMP_W-1:0] pair_new,
    input  logic               ready,
    output logic               valid,
    output logic [STAMP_W-1:0] arrival,
    output logic [STAMP_W-1:0] fall,
    output logic               lost
);
    logic take;

    assign take = req & (~valid | ready);

    // Hold, load or release the event slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            arrival <= '0;
            fall    <= '0;
        end else if (take) begin
            valid   <= 1'b1;
            arrival <= pair_old;
            fall    <= pair_new;
        end else if (valid && ready) begin
            valid   <= 1'b0;
        end
    end

    // Record any request dropped under back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lost <= 1'b0;
        else if (req && valid && !ready) lost <= 1'b1;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(arrival) && $stable(fall))); // R7
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> lost); // R8
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && valid && !ready) |=> lost); // R8
endmodule

// File: rtl/hit_event_builder.sv
// Top of the hit event builder: synchronizes the converter strobes, keeps
// the two latest stamps, clears the converter and forms events in pair or
// every-stamp mode behind a valid/ready output.
// Assumes: the energy flag rises together with the data-ready strobe of the
// stamp that closes a pulse; strobes are spaced by at least eight cycles.
module hit_event_builder #(
    parameter int unsigned STAMP_W = heb_pkg::STAMP_W_DEF,
    parameter int unsigned SYNC_N  = heb_pkg::SYNC_DEF,
    parameter int unsigned CLR_CYC = heb_pkg::CLR_CYC_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tdc_ready_a,
    input  logic               tdc_energy_a,
    input  logic [STAMP_W-1:0] tdc_stamp,
    input  logic               all_mode,
    output logic               tdc_clr_n,
    output logic               evt_valid,
    input  logic               evt_ready,
    output logic [STAMP_W-1:0] evt_arrival,
    output logic [STAMP_W-1:0] evt_fall,
    output logic               evt_lost
);
    import heb_pkg::*;

    logic               hit_p;
    logic               nrg_p;
    logic               hit_d_q;
    logic               nrg_d_q;
    logic               req;
    logic [STAMP_W-1:0] st_new;
    logic [STAMP_W-1:0] st_old;
    build_mode_e        mode;

    heb_edge_sync #(.STAGES(SYNC_N)) u_sync_ready (
        .clk(clk), .rst_n(rst_n), .async_in(tdc_ready_a), .rise_p(hit_p)
    );

    heb_edge_sync #(.STAGES(SYNC_N)) u_sync_energy (
        .clk(clk), .rst_n(rst_n), .async_in(tdc_energy_a), .rise_p(nrg_p)
    );

    heb_stamp_row #(.STAMP_W(STAMP_W), .CLR_CYC(CLR_CYC)) u_row (
        .clk(clk), .rst_n(rst_n), .hit_p(hit_p), .stamp(tdc_stamp),
        .newest(st_new), .older(st_old), .clr_n(tdc_clr_n)
    );

    // Delay both request sources so they follow the stamp shift by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_d_q <= 1'b0;
            nrg_d_q <= 1'b0;
        end else begin
            hit_d_q <= hit_p;
            nrg_d_q <= nrg_p;
        end
    end

    assign mode = build_mode_e'(all_mode);
    assign req  = pick_req(mode, hit_d_q, nrg_d_q);

    heb_event_out #(.STAMP_W(STAMP_W)) u_out (
        .clk(clk), .rst_n(rst_n), .req(req),
        .pair_old(st_old), .pair_new(st_new), .ready(evt_ready),
        .valid(evt_valid), .arrival(evt_arrival), .fall(evt_fall),
        .lost(evt_lost)
    );

    AST_EVERY_MODE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (all_mode && hit_d_q && (!evt_valid || evt_ready)) |=> evt_valid); // R5
    AST_PAIR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_mode && !nrg_d_q && !evt_valid) |=> !evt_valid); // R4
endmodule

// File: tb/sim_hit_event_builder.sv
module sim_hit_event_builder;
    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tdc_ready_a = 1'b0;
    logic         tdc_energy_a = 1'b0;
    logic [W-1:0] tdc_stamp = '0;
    logic         all_mode = 1'b0;
    logic         tdc_clr_n;
    logic         evt_valid;
    logic         evt_ready = 1'b1;
    logic [W-1:0] evt_arrival;
    logic [W-1:0] evt_fall;
    logic         evt_lost;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state
    logic         m_v = 1'b0;
    logic         m_lost = 1'b0;
    logic [W-1:0] m_new = '0;
    logic [W-1:0] m_old = '0;
    logic [W-1:0] m_arr = '0;
    logic [W-1:0] m_fall = '0;

    hit_event_builder #(.STAMP_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tdc_ready_a(tdc_ready_a),
        .tdc_energy_a(tdc_energy_a), .tdc_stamp(tdc_stamp), .all_mode(all_mode),
        .tdc_clr_n(tdc_clr_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_arrival(evt_arrival), .evt_fall(evt_fall), .evt_lost(evt_lost)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic want_event(logic mode, logic energy);
        return mode | energy;
    endfunction

    function automatic logic want_clr_n(int e);
        return !(e == 3 || e == 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One converter measurement; hold = extra cycles the ready level stays high.
    task automatic run_hit(logic [W-1:0] st, logic energy, logic mode, logic rdy, int hold);
        logic ev;
        ev = want_event(mode, energy);
        @(negedge clk);
        all_mode = mode;
        evt_ready = rdy;
        tdc_stamp = st;
        tdc_ready_a = 1'b1;
        tdc_energy_a = energy;
        for (int e = 0; e < 8 + hold; e++) begin
            @(posedge clk);
            if (e == 3) begin
                m_old = m_new;
                m_new = st;
            end
            if (e == 4 && ev) begin
                if (!m_v || rdy) begin
                    m_v = 1'b1;
                    m_arr = m_old;
                    m_fall = m_new;
                end else begin
                    m_lost = 1'b1;
                end
            end else if (m_v && rdy) begin
                m_v = 1'b0;
            end
            @(negedge clk);
            if (e == 3) begin
                tdc_stamp = ~st;      // R9: late change must not be captured
                tdc_energy_a = 1'b0;
            end
            if (e == 3 + hold) tdc_ready_a = 1'b0;
            chk("R3/R1 clear pulse", 32'(tdc_clr_n), 32'(want_clr_n(e)));
            chk("R6/R7 valid", 32'(evt_valid), 32'(m_v));
            chk("R8 lost", 32'(evt_lost), 32'(m_lost));
            if (m_v) begin
                chk("R2/R9 arrival", 32'(evt_arrival), 32'(m_arr));
                chk("R2/R9 fall", 32'(evt_fall), 32'(m_fall));
            end
        end
    endtask

    initial begin
        void'($urandom(32'h0000_5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset valid", 32'(evt_valid), 32'd0);
        chk("R10 reset lost", 32'(evt_lost), 32'd0);
        chk("R10 reset clear", 32'(tdc_clr_n), 32'd1);

        // R4: pair mode, no energy flag: no event; then with flag: event
        run_hit(16'h1111, 1'b0, 1'b0, 1'b1, 0);
        run_hit(16'h2222, 1'b1, 1'b0, 1'b1, 0);
        // R5: every-stamp mode without energy flag
        run_hit(16'h3333, 1'b0, 1'b1, 1'b1, 0);
        // R1: level held high for many cycles gives one clear and one event
        run_hit(16'h4444, 1'b0, 1'b1, 1'b1, 15);
        // R7/R8: back-pressure, then a dropped request, then release
        run_hit(16'h5555, 1'b0, 1'b1, 1'b0, 0);
        run_hit(16'h6666, 1'b1, 1'b1, 1'b0, 0);
        run_hit(16'h7777, 1'b0, 1'b1, 1'b1, 0);

        // Reset again so the random phase exercises the lost flag afresh (R10)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_v = 1'b0; m_lost = 1'b0; m_new = '0; m_old = '0;
        @(negedge clk);
        chk("R10 second reset lost", 32'(evt_lost), 32'd0);

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] st;
            logic en, md, rd;
            st = W'($urandom);
            en = 1'($urandom);
            md = 1'($urandom);
            rd = ($urandom % 4) != 0;
            run_hit(st, en, md, rd, int'($urandom % 4));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule